// File: doc/BRIEF.md
# SGI Affinity Target Dispatcher

This block turns one 64-bit software-generated-interrupt request word into a series of per-processor signalling pulses. It keeps no processor table of its own. The affinity value of each of `NUM_PROC` processors comes in on a flat input vector, and so do two small per-processor, per-interrupt bit arrays. One array gives each interrupt's group, and the other marks which interrupts are hardware-backed.

When the block is idle it accepts a request and scans the processors in index order, one per clock. In targeted mode a processor is hit when its three upper affinity bytes equal those in the request and its level-0 byte selects a set bit of the 16-bit target list. That bit is then removed from a working copy of the list, and the scan stops once the copy is empty. In broadcast mode every processor except the requester is hit. A hit that passes the group filter yields a pending-set pulse, or an inject-request pulse when the interrupt is hardware-backed. A done pulse closes each scan.

Top module: `sgi_affinity_dispatch`

## Requirements
- R1: The request is split into these fields: interrupt number in bits 27:24, level-1 affinity in 23:16, level-2 in 39:32, level-3 in 55:48, broadcast flag in bit 40 and target list in 15:0. A request is taken only when `busy` is low, and a request offered while `busy` is high has no effect on the scan in progress.
- R2: In targeted mode a processor is hit only if bits 15:8, 23:16 and 31:24 of its affinity equal the request's level-1, level-2 and level-3 fields, its level-0 byte (bits 7:0) is below 16, and that bit of the working target list is set.
- R3: Each targeted hit clears its bit in the working list, so a later processor with the same affinity is not hit. The scan ends in the cycle where the working list becomes, or already is, zero.
- R4: In broadcast mode every processor whose index differs from `reqSrcIdx` is hit and the target list is ignored. The scan then covers all `NUM_PROC` processors.
- R5: Interrupts whose group bit (`sgiGroup[p*16+id]`) is 0 are always signalled. Interrupts whose group bit is 1 are signalled only when `reqAllowG1` was high with the request, and are otherwise dropped with no pulse.
- R6: A signalled hit drives `injValid` when `sgiHw[p*16+id]` is 1 and `pendValid` otherwise, never both together. `sigProc` carries the processor index and `sigSgi` carries the interrupt number.
- R7: Processor k is evaluated in the k-th cycle after acceptance. `busy` stays high for exactly the number of cycles scanned.
- R8: The pulse for a processor appears one cycle after that processor's scan cycle. `done` rises for one cycle together with the pulse of the final scan cycle, and `busy` is already low at that point.
- R9: After reset, `busy`, `pendValid`, `injValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqWord | input | 64 | Request word |
| reqAllowG1 | input | 1 | Access may raise group-1 interrupts |
| reqSrcIdx | input | IDX_W | Index of the requesting processor |
| procAffinity | input | NUM_PROC*32 | Affinity of each processor, 32 bits each |
| sgiGroup | input | NUM_PROC*16 | Group bit per processor and interrupt |
| sgiHw | input | NUM_PROC*16 | Hardware-backed flag per processor and interrupt |
| busy | output | 1 | Scan in progress |
| pendValid | output | 1 | Set-pending pulse |
| injValid | output | 1 | External inject-request pulse |
| sigProc | output | IDX_W | Processor index of the pulse |
| sigSgi | output | 4 | Interrupt number of the pulse |
| done | output | 1 | Scan finished |

## Verification
Random tables are built from a small set of affinity values, so many processors share upper bytes and some share a whole affinity. Against these tables the bench sends random targeted and broadcast requests with random group and hardware maps. This separates a correct upper-byte compare from a level-0-only match, and shows whether the working list stops a duplicate from being hit twice. Directed cases then cover an empty list (one-cycle scan), level-0 values of 16 or more (never hit, full scan), broadcast with the requester at either end of the table, group-1 dropping under both settings of the allow input, hardware injection, and a second request offered while busy. The ordered pulse list and the busy length of every scan are compared against a reference model in the bench.

// File: rtl/sgi_affinity_dispatch_pkg.sv
package sgi_affinity_dispatch_pkg;

  localparam int SGI_NUM  = 16;
  localparam int SGI_W    = 4;
  localparam int AFF_W    = 32;
  localparam int LIST_W   = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic eval;
    logic finish;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [SGI_W-1:0]  sgiId;
    logic [7:0]        aff1;
    logic [7:0]        aff2;
    logic [7:0]        aff3;
    logic              bcast;
    logic [LIST_W-1:0] targets;
  } sgiReq_t;

  function automatic sgiReq_t decodeReq(input logic [63:0] w);
    sgiReq_t r;
    r.sgiId   = w[27:24];
    r.aff1    = w[23:16];
    r.aff2    = w[39:32];
    r.aff3    = w[55:48];
    r.bcast   = w[40];
    r.targets = w[15:0];
    return r;
  endfunction

endpackage

// File: rtl/sgi_affinity_dispatch_ctrl.sv
module sgi_affinity_dispatch_ctrl
  import sgi_affinity_dispatch_pkg::*;
#(
  parameter int NUM_PROC = 8,
  parameter int IDX_W    = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             listClearNext,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] scanIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PROC - 1);

  logic             busyQ;
  logic [IDX_W-1:0] idxQ;

  always_comb begin
    strobes.load   = reqValid && !busyQ;
    strobes.eval   = busyQ;
    strobes.finish = busyQ && ((idxQ == LAST_IDX) || listClearNext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (strobes.load) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
    end else if (strobes.finish) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (strobes.eval) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  assign scanIdx = idxQ;
  assign busy    = busyQ;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |-> (int'(idxQ) < NUM_PROC)); // R7

  AST_SCAN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && !strobes.finish) |=> (busyQ && idxQ == $past(idxQ) + 1'b1)); // R7

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !busyQ) |=> (busyQ && idxQ == '0)); // R1

endmodule

// File: rtl/sgi_affinity_dispatch_dp.sv
module sgi_affinity_dispatch_dp
  import sgi_affinity_dispatch_pkg::*;
#(
  parameter int NUM_PROC = 8,
  parameter int IDX_W    = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrlStrobes_t               strobes,
  input  logic [IDX_W-1:0]           scanIdx,
  input  logic [63:0]                reqWord,
  input  logic                       reqAllowG1,
  input  logic [IDX_W-1:0]           reqSrcIdx,
  input  logic [NUM_PROC*AFF_W-1:0]  procAffinity,
  input  logic [NUM_PROC*SGI_NUM-1:0] sgiGroup,
  input  logic [NUM_PROC*SGI_NUM-1:0] sgiHw,
  output logic                       listClearNext,
  output logic                       pendValid,
  output logic                       injValid,
  output logic [IDX_W-1:0]           sigProc,
  output logic [SGI_W-1:0]           sigSgi,
  output logic                       done
);

  // per-processor views of the flat tables
  logic [AFF_W-1:0]   affArr [NUM_PROC];
  logic [SGI_NUM-1:0] grpArr [NUM_PROC];
  logic [SGI_NUM-1:0] hwArr  [NUM_PROC];

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_unpack
    assign affArr[g] = procAffinity[g*AFF_W +: AFF_W];
    assign grpArr[g] = sgiGroup[g*SGI_NUM +: SGI_NUM];
    assign hwArr[g]  = sgiHw[g*SGI_NUM +: SGI_NUM];
  end

  sgiReq_t           reqQ;
  logic              allowQ;
  logic [IDX_W-1:0]  srcQ;
  logic [LIST_W-1:0] workList;
  logic              grp1Q;

  logic [AFF_W-1:0]  curAff;
  logic [7:0]        lvl0;
  logic              upperHit;
  logic              inList;
  logic              tgtHit;
  logic              bcastHit;
  logic              hit;
  logic              curGrp;
  logic              curHw;
  logic              allowed;
  logic [LIST_W-1:0] listNext;

  always_comb begin
    curAff   = affArr[scanIdx];
    lvl0     = curAff[7:0];
    upperHit = (curAff[15:8]  == reqQ.aff1) &&
               (curAff[23:16] == reqQ.aff2) &&
               (curAff[31:24] == reqQ.aff3);
    inList   = (lvl0[7:4] == 4'd0) && workList[lvl0[3:0]];
    tgtHit   = !reqQ.bcast && upperHit && inList;
    bcastHit = reqQ.bcast && (scanIdx != srcQ);
    hit      = strobes.eval && (tgtHit || bcastHit);
    curGrp   = grpArr[scanIdx][reqQ.sgiId];
    curHw    = hwArr[scanIdx][reqQ.sgiId];
    allowed  = !curGrp || allowQ;
    listNext = workList;
    if (tgtHit) listNext[lvl0[3:0]] = 1'b0;
    listClearNext = !reqQ.bcast && (listNext == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ     <= '0;
      allowQ   <= 1'b0;
      srcQ     <= '0;
      workList <= '0;
    end else if (strobes.load) begin
      reqQ     <= decodeReq(reqWord);
      allowQ   <= reqAllowG1;
      srcQ     <= reqSrcIdx;
      workList <= decodeReq(reqWord).targets;
    end else if (strobes.eval) begin
      workList <= listNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      injValid  <= 1'b0;
      sigProc   <= '0;
      sigSgi    <= '0;
      grp1Q     <= 1'b0;
      done      <= 1'b0;
    end else begin
      pendValid <= hit && allowed && !curHw;
      injValid  <= hit && allowed && curHw;
      sigProc   <= scanIdx;
      sigSgi    <= reqQ.sgiId;
      grp1Q     <= curGrp;
      done      <= strobes.finish;
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(pendValid && injValid)); // R6

  AST_G1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pendValid || injValid) |-> (!grp1Q || allowQ)); // R5

  AST_NO_SELF_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendValid || injValid) && reqQ.bcast) |-> (sigProc != srcQ)); // R4

  AST_LIST_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.eval && tgtHit) |=>
      ($countones(workList) == $countones($past(workList)) - 1)); // R3

endmodule

// File: rtl/sgi_affinity_dispatch.sv
module sgi_affinity_dispatch
  import sgi_affinity_dispatch_pkg::*;
#(
  parameter int NUM_PROC = 8,
  parameter int IDX_W    = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reqValid,
  input  logic [63:0]                 reqWord,
  input  logic                        reqAllowG1,
  input  logic [IDX_W-1:0]            reqSrcIdx,
  input  logic [NUM_PROC*32-1:0]      procAffinity,
  input  logic [NUM_PROC*16-1:0]      sgiGroup,
  input  logic [NUM_PROC*16-1:0]      sgiHw,
  output logic                        busy,
  output logic                        pendValid,
  output logic                        injValid,
  output logic [IDX_W-1:0]            sigProc,
  output logic [3:0]                  sigSgi,
  output logic                        done
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] scanIdx;
  logic             listClearNext;

  sgi_affinity_dispatch_ctrl #(.NUM_PROC(NUM_PROC), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reqValid      (reqValid),
    .listClearNext (listClearNext),
    .strobes       (strobes),
    .scanIdx       (scanIdx),
    .busy          (busy)
  );

  sgi_affinity_dispatch_dp #(.NUM_PROC(NUM_PROC), .IDX_W(IDX_W)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .scanIdx       (scanIdx),
    .reqWord       (reqWord),
    .reqAllowG1    (reqAllowG1),
    .reqSrcIdx     (reqSrcIdx),
    .procAffinity  (procAffinity),
    .sgiGroup      (sgiGroup),
    .sgiHw         (sgiHw),
    .listClearNext (listClearNext),
    .pendValid     (pendValid),
    .injValid      (injValid),
    .sigProc       (sigProc),
    .sigSgi        (sigSgi),
    .done          (done)
  );

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_PULSE_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (pendValid || injValid) |-> $past(busy)); // R8

endmodule

// File: tb/sgi_affinity_dispatch_tb.sv
module sgi_affinity_dispatch_tb;

  localparam int NP = 8;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reqValid = 1'b0;
  logic [63:0]     reqWord = '0;
  logic            reqAllowG1 = 1'b0;
  logic [IW-1:0]   reqSrcIdx = '0;
  logic [NP*32-1:0] procAffinity = '0;
  logic [NP*16-1:0] sgiGroup = '0;
  logic [NP*16-1:0] sgiHw = '0;
  logic            busy, pendValid, injValid, done;
  logic [IW-1:0]   sigProc;
  logic [3:0]      sigSgi;

  always #10 clk = ~clk;  // 50 MHz

  sgi_affinity_dispatch #(.NUM_PROC(NP)) u_dut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected events: kind 1 = pending set, 2 = inject
  int expN, expCyc;
  int expProc [NP];
  int expKind [NP];

  function automatic logic [63:0] mkWord(int sgi, int a1, int a2, int a3, bit bc, int lst);
    logic [63:0] w = '0;
    w[27:24] = 4'(sgi); w[23:16] = 8'(a1); w[39:32] = 8'(a2);
    w[55:48] = 8'(a3);  w[40] = bc;        w[15:0] = 16'(lst);
    return w;
  endfunction

  task automatic model(input logic [63:0] w, input bit allow, input int src);
    logic [15:0] lst = w[15:0];
    int sgi = int'(w[27:24]);
    bit bc = w[40];
    expN = 0; expCyc = 0;
    for (int p = 0; p < NP; p++) begin
      logic [31:0] a = procAffinity[p*32 +: 32];
      bit h = 0;
      expCyc++;
      if (bc) h = (p != src);
      else if (a[15:8] == w[23:16] && a[23:16] == w[39:32] && a[31:24] == w[55:48]
               && a[7:0] < 16 && lst[a[3:0]]) begin
        h = 1; lst[a[3:0]] = 1'b0;
      end
      if (h && (!sgiGroup[p*16+sgi] || allow)) begin
        expProc[expN] = p;
        expKind[expN] = sgiHw[p*16+sgi] ? 2 : 1;
        expN++;
      end
      if (!bc && lst == 0) break;
    end
  endtask

  task automatic runReq(input logic [63:0] w, input bit allow, input int src,
                        input bit intrude, input string tag);
    int gotN = 0, busyCyc = 0, gotProc [NP], gotKind [NP];
    bit fin = 0;
    model(w, allow, src);
    @(negedge clk);
    reqWord = w; reqAllowG1 = allow; reqSrcIdx = IW'(src); reqValid = 1'b1;
    for (int c = 0; c < 4*NP && !fin; c++) begin
      @(negedge clk);
      if (c == 0 && intrude) begin
        reqWord = ~w; reqAllowG1 = ~allow; reqSrcIdx = IW'(src + 1);
      end else reqValid = 1'b0;
      if (busy) busyCyc++;
      if (pendValid || injValid) begin
        if (gotN < NP) begin
          gotProc[gotN] = int'(sigProc);
          gotKind[gotN] = injValid ? 2 : 1;
          chk(int'(sigSgi) == int'(w[27:24]), {tag, " R6 sgi id"}, int'(sigSgi), int'(w[27:24]));
        end
        gotN++;
      end
      if (done) fin = 1;
    end
    reqValid = 1'b0;
    chk(fin, {tag, " R8 done seen"}, int'(fin), 1);
    chk(gotN == expN, {tag, " R2 pulse count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      chk(gotProc[i] == expProc[i], {tag, " R7 pulse proc"}, gotProc[i], expProc[i]);
      chk(gotKind[i] == expKind[i], {tag, " R6 pulse kind"}, gotKind[i], expKind[i]);
    end
    chk(busyCyc == expCyc, {tag, " R3 scan length"}, busyCyc, expCyc);
    @(negedge clk);
    chk(!busy && !pendValid && !injValid, {tag, " R1 quiet after"},
        int'({busy, pendValid, injValid}), 0);
  endtask

  function automatic logic [31:0] mkAff(int l0, int a1, int a2, int a3);
    return {8'(a3), 8'(a2), 8'(a1), 8'(l0)};
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !pendValid && !injValid && !done, "R9 reset state",
        int'({busy, pendValid, injValid, done}), 0);
    rst_n = 1'b1;

    // directed: duplicate affinity, early stop (R3, R2)
    for (int p = 0; p < NP; p++) procAffinity[p*32 +: 32] = mkAff(p, 1, 2, 3);
    procAffinity[5*32 +: 32] = mkAff(2, 1, 2, 3);
    procAffinity[6*32 +: 32] = mkAff(4, 1, 2, 9);   // level-3 mismatch
    sgiGroup = '0; sgiHw = '0;
    runReq(mkWord(5, 1, 2, 3, 0, 16'h0004), 0, 0, 0, "dup R3");
    runReq(mkWord(5, 1, 2, 3, 0, 16'h0050), 0, 0, 0, "lvl3 R2");
    // empty list: one cycle, no pulses
    runReq(mkWord(1, 1, 2, 3, 0, 0), 1, 0, 0, "empty R3");
    // level 0 of 16 or more never matches, full scan
    for (int p = 0; p < NP; p++) procAffinity[p*32 +: 32] = mkAff(16 + p, 0, 0, 0);
    runReq(mkWord(2, 0, 0, 0, 0, 16'hFFFF), 1, 0, 0, "l0big R2");
    // broadcast, requester at both ends, list ignored
    runReq(mkWord(3, 7, 7, 7, 1, 0), 0, 0, 0, "bcast0 R4");
    runReq(mkWord(3, 7, 7, 7, 1, 16'hFFFF), 0, NP-1, 0, "bcastN R4");
    // group 1 dropped, then allowed; hardware inject
    sgiGroup = '1; sgiHw = '0;
    runReq(mkWord(9, 0, 0, 0, 1, 0), 0, 2, 0, "g1drop R5");
    runReq(mkWord(9, 0, 0, 0, 1, 0), 1, 2, 0, "g1allow R5");
    sgiGroup = '0; sgiHw = '1;
    runReq(mkWord(9, 0, 0, 0, 1, 0), 0, 3, 0, "hw R6");
    // request while busy is ignored
    sgiHw = '0;
    runReq(mkWord(4, 0, 0, 0, 1, 0), 0, 1, 1, "intrude R1");

    // random
    for (int t = 0; t < 300; t++) begin
      for (int p = 0; p < NP; p++)
        procAffinity[p*32 +: 32] = mkAff($urandom_range(0, 17), $urandom_range(0, 1),
                                         0, $urandom_range(0, 1));
      for (int p = 0; p < NP; p++) begin
        sgiGroup[p*16 +: 16] = 16'($urandom);
        sgiHw[p*16 +: 16]    = 16'($urandom);
      end
      runReq(mkWord($urandom_range(0, 15), $urandom_range(0, 1), 0, $urandom_range(0, 1),
                    ($urandom_range(0, 9) < 3), $urandom),
             1'($urandom), $urandom_range(0, NP-1), 1'($urandom), "rand R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule